// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit with Carry

This unit moves an operand by exactly one bit position and produces the condition flags that go with the result. It covers logical and arithmetic shifts in both directions, plain rotates, rotates that pass through the carry flag, and a bitwise complement. The operand can be a byte, a word or a long, chosen by a size select. The top bit of the operand, the bit that feeds the carry and the bit that refills the vacated position all follow that size.

A datapath puts the operand, the current carry flag, an operation code and the size on the inputs. One clock later the unit returns the result, zero-extended to the full long width, together with the negative, zero, overflow and carry flags. The caller writes the result back to the register it read from. The unit has no multi-bit counts and no barrel shifter. Each of the three operand widths gets its own lane, and the size select picks one lane's output.

Top module: `shrot_unit`

## Requirements
- R1: Operation codes 0 and 1 (logical and arithmetic shift left) put the old top bit of the selected width into C and a zero into bit 0.
- R2: Operation code 2 (logical shift right) puts old bit 0 into C and a zero into the top bit.
- R3: Operation code 3 (arithmetic shift right) puts old bit 0 into C and keeps the old top bit in the top bit.
- R4: Operation code 4 (rotate left) copies the old top bit into both bit 0 and C.
- R5: Operation code 5 (rotate right) copies old bit 0 into both the top bit and C.
- R6: Operation code 6 (rotate left through carry) puts the incoming carry into bit 0 and the old top bit into C.
- R7: Operation code 7 (rotate right through carry) puts the incoming carry into the top bit and old bit 0 into C.
- R8: Operation code 8 inverts every bit inside the selected width and returns the incoming carry unchanged as C.
- R9: Size code 0 selects 8 bits (top bit 7), code 1 selects 16 bits (top bit 15), and codes 2 and 3 select 32 bits (top bit 31). Result bits above the selected width are zero, and operand bits above it have no effect.
- R10: N equals the top bit of the result within the selected width, Z is 1 exactly when the result within that width is zero, and V is always 0.
- R11: Operation codes 9 to 15 return the operand within the selected width unchanged, return the incoming carry as C, and set N and Z from that result.
- R12: All outputs are registered with one cycle of latency, and an active-low reset clears the result and all flags to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| operand_i | input | 32 | Operand; only the bits inside the selected width are used |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size select |
| result_o | output | 32 | Result, zero above the selected width |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag, always 0 |
| c_o | output | 1 | Carry flag |

## Verification
The bench sweeps every operation code, all four size codes and both carry values over a set of operands. The operand set includes values whose set bits sit only at 7, 15 or 31, and values with set bits above the byte width. A unit that took the top bit from a fixed position shows up on those operands as a wrong carry or a wrong refill bit in the byte and word sizes. A unit that let upper operand bits leak into the result would fail the zero flag or the zero-extension check. Running the through-carry rotates with both carry values shows whether the incoming carry, rather than an operand bit, lands in the vacated slot. The complement and unused codes are checked for an unchanged carry, which catches a unit that reuses a shift's carry-out.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
   localparam int OP_W   = 4;
   localparam int SIZE_W = 2;
   localparam int NLANES = 3;

   typedef enum logic [OP_W-1:0] {
      OP_SHL_LOG = 4'd0,
      OP_SHL_ARI = 4'd1,
      OP_SHR_LOG = 4'd2,
      OP_SHR_ARI = 4'd3,
      OP_ROT_L   = 4'd4,
      OP_ROT_R   = 4'd5,
      OP_ROTC_L  = 4'd6,
      OP_ROTC_R  = 4'd7,
      OP_INVERT  = 4'd8
   } shrot_op_e;

   typedef enum logic [SIZE_W-1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2
   } shrot_size_e;
endpackage

// File: rtl/shrot_lane.sv
module shrot_lane
   import shrot_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0]    a_i,
   input  logic            cin_i,
   input  logic [OP_W-1:0] op_i,
   output logic [W-1:0]    res_o,
   output logic            cout_o
);
   localparam int TOP = W - 1;

   if (W < 2) begin : g_bad_w
      $error("shrot_lane: W must be at least 2");
   end

   shrot_op_e op;
   assign op = shrot_op_e'(op_i);

   always_comb begin
      res_o  = a_i;
      cout_o = cin_i;
      case (op)
         OP_SHL_LOG, OP_SHL_ARI: begin
            res_o  = {a_i[TOP-1:0], 1'b0};
            cout_o = a_i[TOP];
         end
         OP_SHR_LOG: begin
            res_o  = {1'b0, a_i[TOP:1]};
            cout_o = a_i[0];
         end
         OP_SHR_ARI: begin
            res_o  = {a_i[TOP], a_i[TOP:1]};
            cout_o = a_i[0];
         end
         OP_ROT_L: begin
            res_o  = {a_i[TOP-1:0], a_i[TOP]};
            cout_o = a_i[TOP];
         end
         OP_ROT_R: begin
            res_o  = {a_i[0], a_i[TOP:1]};
            cout_o = a_i[0];
         end
         OP_ROTC_L: begin
            res_o  = {a_i[TOP-1:0], cin_i};
            cout_o = a_i[TOP];
         end
         OP_ROTC_R: begin
            res_o  = {cin_i, a_i[TOP:1]};
            cout_o = a_i[0];
         end
         OP_INVERT: begin
            res_o  = ~a_i;
            cout_o = cin_i;
         end
         default: begin
            res_o  = a_i;
            cout_o = cin_i;
         end
      endcase
   end
endmodule

// File: rtl/shrot_select.sv
module shrot_select
   import shrot_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16,
   parameter int LONG_W = 32
) (
   input  logic [SIZE_W-1:0] size_i,
   input  logic [LONG_W-1:0] byte_res_i,
   input  logic [LONG_W-1:0] word_res_i,
   input  logic [LONG_W-1:0] long_res_i,
   input  logic              byte_c_i,
   input  logic              word_c_i,
   input  logic              long_c_i,
   output logic [LONG_W-1:0] res_o,
   output logic              n_o,
   output logic              z_o,
   output logic              c_o
);
   shrot_size_e sz;
   assign sz = shrot_size_e'(size_i);

   always_comb begin
      case (sz)
         SZ_BYTE: begin
            res_o = byte_res_i;
            c_o   = byte_c_i;
            n_o   = byte_res_i[BYTE_W-1];
         end
         SZ_WORD: begin
            res_o = word_res_i;
            c_o   = word_c_i;
            n_o   = word_res_i[WORD_W-1];
         end
         default: begin
            res_o = long_res_i;
            c_o   = long_c_i;
            n_o   = long_res_i[LONG_W-1];
         end
      endcase
      z_o = (res_o == '0);
   end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16,
   parameter int LONG_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LONG_W-1:0] operand_i,
   input  logic              carry_i,
   input  logic [OP_W-1:0]   op_i,
   input  logic [SIZE_W-1:0] size_i,
   output logic [LONG_W-1:0] result_o,
   output logic              n_o,
   output logic              z_o,
   output logic              v_o,
   output logic              c_o
);
   if (BYTE_W < 2 || WORD_W <= BYTE_W || LONG_W <= WORD_W) begin : g_bad_widths
      $error("shrot_unit: widths must satisfy 2 <= BYTE_W < WORD_W < LONG_W");
   end

   logic [LONG_W-1:0] lane_res [NLANES];
   logic              lane_c   [NLANES];

   for (genvar g = 0; g < NLANES; g++) begin : g_lane
      localparam int LW = (g == 0) ? BYTE_W : ((g == 1) ? WORD_W : LONG_W);
      logic [LW-1:0] res_w;
      shrot_lane #(.W(LW)) u_lane (
         .a_i    (operand_i[LW-1:0]),
         .cin_i  (carry_i),
         .op_i   (op_i),
         .res_o  (res_w),
         .cout_o (lane_c[g])
      );
      if (LW < LONG_W) begin : g_ext
         assign lane_res[g] = {{(LONG_W-LW){1'b0}}, res_w};
      end else begin : g_full
         assign lane_res[g] = res_w;
      end
   end

   logic [LONG_W-1:0] sel_res;
   logic              sel_n, sel_z, sel_c;

   shrot_select #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .LONG_W(LONG_W)) u_sel (
      .size_i     (size_i),
      .byte_res_i (lane_res[0]),
      .word_res_i (lane_res[1]),
      .long_res_i (lane_res[2]),
      .byte_c_i   (lane_c[0]),
      .word_c_i   (lane_c[1]),
      .long_c_i   (lane_c[2]),
      .res_o      (sel_res),
      .n_o        (sel_n),
      .z_o        (sel_z),
      .c_o        (sel_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         n_o      <= 1'b0;
         z_o      <= 1'b0;
         v_o      <= 1'b0;
         c_o      <= 1'b0;
      end else begin
         result_o <= sel_res;
         n_o      <= sel_n;
         z_o      <= sel_z;
         v_o      <= 1'b0;
         c_o      <= sel_c;
      end
   end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk
   import shrot_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16,
   parameter int LONG_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LONG_W-1:0] operand_i,
   input logic              carry_i,
   input logic [OP_W-1:0]   op_i,
   input logic [SIZE_W-1:0] size_i,
   input logic [LONG_W-1:0] result_o,
   input logic              n_o,
   input logic              z_o,
   input logic              v_o,
   input logic              c_o
);
   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   a_r10_zero_flag: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      z_o == (result_o == '0));

   a_r10_neg_flag: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      n_o == (($past(size_i) == 2'd0) ? result_o[BYTE_W-1] :
              ($past(size_i) == 2'd1) ? result_o[WORD_W-1] : result_o[LONG_W-1]));

   a_r9_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      ($past(size_i) == 2'd0) |-> (result_o[LONG_W-1:BYTE_W] == '0));

   a_r1_long_left: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      ($past(op_i) == 4'd0 && $past(size_i) == 2'd2) |->
         (result_o == {$past(operand_i[LONG_W-2:0]), 1'b0} && c_o == $past(operand_i[LONG_W-1])));

   a_r5_long_rotr: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      ($past(op_i) == 4'd5 && $past(size_i) == 2'd2) |->
         (result_o[LONG_W-1] == c_o && c_o == $past(operand_i[0])));

   a_r7_rotc_right_msb: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      ($past(op_i) == 4'd7 && $past(size_i) == 2'd2) |-> (result_o[LONG_W-1] == $past(carry_i)));

   a_r8_invert_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      ($past(op_i) == 4'd8) |-> (c_o == $past(carry_i)));
endmodule

bind shrot_unit shrot_unit_chk #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .LONG_W(LONG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .operand_i (operand_i),
   .carry_i   (carry_i),
   .op_i      (op_i),
   .size_i    (size_i),
   .result_o  (result_o),
   .n_o       (n_o),
   .z_o       (z_o),
   .v_o       (v_o),
   .c_o       (c_o)
);

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NPAT = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] operand_i = '0;
   logic        carry_i = 1'b0;
   logic [3:0]  op_i = '0;
   logic [1:0]  size_i = '0;
   logic [31:0] result_o;
   logic        n_o, z_o, v_o, c_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shrot_unit dut (
      .clk(clk), .rst_n(rst_n), .operand_i(operand_i), .carry_i(carry_i),
      .op_i(op_i), .size_i(size_i), .result_o(result_o),
      .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o)
   );

   function automatic logic [31:0] pattern(int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'hFFFF_FFFF;
         2: return 32'h0000_0001;
         3: return 32'h8000_0000;
         4: return 32'h0000_8000;
         5: return 32'h0000_0080;
         6: return 32'h7FFF_FFFF;
         7: return 32'hAAAA_AAAA;
         8: return 32'hFFFF_FF00;
         9: return 32'h0001_0000;
         default: return (i * 32'h9E37_79B9) ^ (i << 7);
      endcase
   endfunction

   function automatic string req_of(int op, int sz);
      if (op <= 1) return "R1";
      if (op == 2) return "R2";
      if (op == 3) return "R3";
      if (op == 4) return "R4";
      if (op == 5) return "R5";
      if (op == 6) return "R6";
      if (op == 7) return "R7";
      if (op == 8) return "R8";
      if (sz == 3) return "R9";
      return "R11";
   endfunction

   task automatic check(string req, logic [35:0] act, logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual res/n/z/v/c=%h expected %h", req, act, exp);
      end
   endtask

   task automatic run_one(int sz, int op, bit cin, logic [31:0] a);
      longint w, mask, hb, x, r;
      bit msb, lsb, c, n, z;
      @(negedge clk);
      operand_i = a; carry_i = cin; op_i = op[3:0]; size_i = sz[1:0];
      w    = (sz == 0) ? 8 : ((sz == 1) ? 16 : 32);
      mask = (longint'(1) << w) - 1;
      hb   = longint'(1) << (w - 1);
      x    = longint'(a) & mask;
      msb  = (x & hb) != 0;
      lsb  = (x & 1) != 0;
      case (op)
         0, 1: begin r = (x * 2) & mask;                c = msb; end
         2:    begin r = x / 2;                         c = lsb; end
         3:    begin r = x / 2 + (msb ? hb : 0);        c = lsb; end
         4:    begin r = ((x * 2) & mask) + (msb ? 1 : 0); c = msb; end
         5:    begin r = x / 2 + (lsb ? hb : 0);        c = lsb; end
         6:    begin r = ((x * 2) & mask) + (cin ? 1 : 0); c = msb; end
         7:    begin r = x / 2 + (cin ? hb : 0);        c = lsb; end
         8:    begin r = mask - x;                      c = cin; end
         default: begin r = x;                          c = cin; end
      endcase
      n = (r & hb) != 0;
      z = (r == 0);
      @(posedge clk);
      #1;
      // R10: N from top bit of the width, Z on zero, V always 0; R12: one-cycle latency
      check(req_of(op, sz), {result_o, n_o, z_o, v_o, c_o}, {r[31:0], n, z, 1'b0, c});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R12: reset clears result and flags
      check("R12", {result_o, n_o, z_o, v_o, c_o}, 36'h0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int sz = 0; sz < 4; sz++)
         for (int op = 0; op < 16; op++)
            for (int ci = 0; ci < 2; ci++)
               for (int p = 0; p < NPAT; p++)
                  run_one(sz, op, ci[0], pattern(p));
      // R9: operand bits above byte width have no effect
      run_one(0, 8, 1'b0, 32'hFFFF_FF00);
      // R11: unused code passes operand through within width
      run_one(1, 12, 1'b1, 32'h1234_8001);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule